// File: doc/BRIEF.md
# Polyphase Tap Storage Bank

This block holds the input samples of a serial polyphase filter: a grid of subfilters (phases) by taps, each cell one complex word. A write presents a sample and a phase index. That phase's delay line moves one place toward its oldest tap, and the new sample enters at tap 0. No other phase changes. The read side takes a phase index and returns every tap of that phase side by side, so a parallel multiply-accumulate stage can consume a whole subfilter at once. Because any single phase can be advanced on its own, the bank supports loading orders in which the number of inputs per output differs from the number of phases.

Storage is arranged as one small memory per tap position, each addressed by the phase index, so selecting a subfilter needs no decoder per tap. A parameter picks between two storage flavours. With combinational read, a load finishes in one clock. With registered read, the bank behaves like cascaded synchronous memories: a load first reads the preceding taps into staging registers and then writes them back shifted, taking two clocks, with a busy flag during the second.

Top module: `polyphase_tap_bank`

## Requirements
- R1: After reset every tap of every phase reads as zero.
- R2: A load to phase p puts the sample in tap 0 of p, moves each tap k of p (k at least 1) to the value tap k-1 held before the load, and discards the old last tap.
- R3: A load to phase p leaves every tap of every other phase unchanged.
- R4: `rdTaps` carries all taps of phase `rdPhase`, with tap k in bits [k*WORD+WORD-1 : k*WORD]; a word holds the I half in its upper 16 bits and the Q half in its lower 16 bits.
- R5: With SYNC_READ=0 the read is combinational and a load sampled at a clock edge is visible on `rdTaps` right after that edge; loads may arrive on consecutive cycles.
- R6: With SYNC_READ=1 a load accepted at edge E raises `busy` for exactly the following cycle, writes at edge E+1, and `rdTaps` (one cycle read latency) shows the new contents after edge E+2.
- R7: With SYNC_READ=1 a read of the phase being loaded returns the pre-load contents until the load's write edge has been followed by one more edge.
- R8: `busy` stays low in the combinational-read build, and `wrEn` must not be raised while `busy` is high.
- R9: A write whose phase index is 5 or more (not below NUM_PHASES) changes nothing and does not raise `busy`.
- R10: A read whose phase index is 5 or more returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load request |
| wrPhase | input | 3 | Phase to load |
| wrSample | input | 32 | Complex sample, I upper half, Q lower half |
| rdPhase | input | 3 | Phase to present on the read port |
| rdTaps | output | 192 | All taps of the read phase, tap 0 least significant |
| busy | output | 1 | Second cycle of a two-cycle load in progress |

## Verification
The bench builds the default 5-phase, 6-tap, 16-bit-half geometry twice, once with SYNC_READ=0 and once with SYNC_READ=1, and drives both from one arithmetic reference that shifts rows itself. With only five phases and a 3-bit index, every phase, every out-of-range index (5 to 7), repeated loads that push words off the end of a line, and reads during each load cycle are all within reach, and the whole bank is swept after each group of loads. The combinational build also takes a burst of back-to-back loads.

// File: rtl/tapbank_pkg.sv
package tapbank_pkg;
  // Strobes from the load sequencer to the storage datapath.
  typedef struct packed {
    logic capture;  // read preceding taps into staging (registered build)
    logic commit;   // write shifted line plus new sample
  } bankCmd_t;
endpackage

// File: rtl/tapbank_ctrl.sv
module tapbank_ctrl
  import tapbank_pkg::*;
#(
  parameter int NUM_PHASES = 5,
  parameter int PHASE_W    = 3,
  parameter int WORD_W     = 32,
  parameter bit SYNC_READ  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [PHASE_W-1:0] wrPhase,
  input  logic [WORD_W-1:0]  wrSample,
  output bankCmd_t           cmd,
  output logic [PHASE_W-1:0] actPhase,
  output logic [WORD_W-1:0]  actSample,
  output logic               busy
);
  localparam logic [PHASE_W:0] PHASE_LIMIT = (PHASE_W+1)'(NUM_PHASES);

  logic reqOk;
  assign reqOk = wrEn && ({1'b0, wrPhase} < PHASE_LIMIT);

  generate
    if (SYNC_READ) begin : g_twoStep
      logic               pending;
      logic [PHASE_W-1:0] pendPhase;
      logic [WORD_W-1:0]  pendSample;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pending    <= 1'b0;
          pendPhase  <= '0;
          pendSample <= '0;
        end else begin
          pending <= cmd.capture;
          if (cmd.capture) begin
            pendPhase  <= wrPhase;
            pendSample <= wrSample;
          end
        end
      end

      always_comb begin
        cmd.capture = reqOk && !pending;
        cmd.commit  = pending;
        actPhase    = pending ? pendPhase : wrPhase;
        actSample   = pendSample;
        busy        = pending;
      end

      // R6
      busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
      // R6
      busy_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reqOk && !busy) |=> busy);
    end else begin : g_oneStep
      always_comb begin
        cmd.capture = 1'b0;
        cmd.commit  = reqOk;
        actPhase    = wrPhase;
        actSample   = wrSample;
        busy        = 1'b0;
      end
    end
  endgenerate

  // R8
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wrEn);
  // R9
  bad_phase_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !reqOk && !busy) |=> !busy);
endmodule

// File: rtl/tapbank_store.sv
module tapbank_store
  import tapbank_pkg::*;
#(
  parameter int NUM_PHASES = 5,
  parameter int NUM_TAPS   = 6,
  parameter int PHASE_W    = 3,
  parameter int WORD_W     = 32,
  parameter bit SYNC_READ  = 1'b0,
  localparam int ROW_W     = NUM_TAPS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bankCmd_t           cmd,
  input  logic [PHASE_W-1:0] actPhase,
  input  logic [WORD_W-1:0]  actSample,
  input  logic [PHASE_W-1:0] rdPhase,
  output logic [ROW_W-1:0]   rdTaps
);
  localparam logic [PHASE_W:0] PHASE_LIMIT = (PHASE_W+1)'(NUM_PHASES);

  // One memory per tap position, addressed by phase.
  logic [WORD_W-1:0] tapMem   [NUM_TAPS][NUM_PHASES];
  // shiftSrc[k] is the word written into tap k+1 of the loaded phase.
  logic [WORD_W-1:0] shiftSrc [NUM_TAPS-1];
  logic [ROW_W-1:0]  phaseRow [NUM_PHASES];
  logic [ROW_W-1:0]  readRow;

  generate
    if (SYNC_READ) begin : g_stage
      logic [WORD_W-1:0] stageWord [NUM_TAPS-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int t = 0; t < NUM_TAPS-1; t++) stageWord[t] <= '0;
        end else if (cmd.capture) begin
          for (int t = 0; t < NUM_TAPS-1; t++) stageWord[t] <= tapMem[t][actPhase];
        end
      end
      always_comb begin
        for (int t = 0; t < NUM_TAPS-1; t++) shiftSrc[t] = stageWord[t];
      end
    end else begin : g_direct
      always_comb begin
        for (int t = 0; t < NUM_TAPS-1; t++) shiftSrc[t] = tapMem[t][actPhase];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TAPS; t++)
        for (int p = 0; p < NUM_PHASES; p++) tapMem[t][p] <= '0;
    end else if (cmd.commit) begin
      tapMem[0][actPhase] <= actSample;
      for (int t = 1; t < NUM_TAPS; t++) tapMem[t][actPhase] <= shiftSrc[t-1];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PHASES; p++)
      for (int t = 0; t < NUM_TAPS; t++)
        phaseRow[p][t*WORD_W +: WORD_W] = tapMem[t][p];
    readRow = '0;
    if ({1'b0, rdPhase} < PHASE_LIMIT) readRow = phaseRow[rdPhase];
  end

  generate
    if (SYNC_READ) begin : g_regRead
      logic [ROW_W-1:0] rdReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdReg <= '0;
        else        rdReg <= readRow;
      end
      assign rdTaps = rdReg;
    end else begin : g_combRead
      assign rdTaps = readRow;
    end
  endgenerate

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.capture && cmd.commit));

  generate
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_rowChk
      // R3
      other_rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.commit && actPhase != PHASE_W'(p)) |=> $stable(phaseRow[p]));
      // R2
      tap0_gets_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.commit && actPhase == PHASE_W'(p)) |=>
          phaseRow[p][WORD_W-1:0] == $past(actSample));
      // R2
      line_shifts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.commit && actPhase == PHASE_W'(p)) |=>
          phaseRow[p][ROW_W-1:WORD_W] == $past(phaseRow[p][ROW_W-WORD_W-1:0]));
    end
  endgenerate
endmodule

// File: rtl/polyphase_tap_bank.sv
module polyphase_tap_bank
  import tapbank_pkg::*;
#(
  parameter int NUM_PHASES = 5,
  parameter int NUM_TAPS   = 6,
  parameter int HALF_W     = 16,
  parameter bit SYNC_READ  = 1'b0,
  localparam int PHASE_W   = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1,
  localparam int WORD_W    = 2 * HALF_W,
  localparam int ROW_W     = NUM_TAPS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [PHASE_W-1:0] wrPhase,
  input  logic [WORD_W-1:0]  wrSample,
  input  logic [PHASE_W-1:0] rdPhase,
  output logic [ROW_W-1:0]   rdTaps,
  output logic               busy
);
  bankCmd_t           cmd;
  logic [PHASE_W-1:0] actPhase;
  logic [WORD_W-1:0]  actSample;

  tapbank_ctrl #(
    .NUM_PHASES(NUM_PHASES), .PHASE_W(PHASE_W), .WORD_W(WORD_W), .SYNC_READ(SYNC_READ)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrPhase(wrPhase), .wrSample(wrSample),
    .cmd(cmd), .actPhase(actPhase), .actSample(actSample), .busy(busy)
  );

  tapbank_store #(
    .NUM_PHASES(NUM_PHASES), .NUM_TAPS(NUM_TAPS), .PHASE_W(PHASE_W),
    .WORD_W(WORD_W), .SYNC_READ(SYNC_READ)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .actPhase(actPhase), .actSample(actSample),
    .rdPhase(rdPhase), .rdTaps(rdTaps)
  );
endmodule

// File: tb/polyphase_tap_bank_test.sv
module polyphase_tap_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5;
  localparam int NT = 6;
  localparam int WW = 32;
  localparam int RW = NT * WW;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEnA = 1'b0, wrEnS = 1'b0;
  logic [PW-1:0] wrPhase = '0, rdPhase = '0;
  logic [WW-1:0] wrSample = '0;
  logic [RW-1:0] tapsA, tapsS;
  logic busyA, busyS;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WW-1:0] modelA [NP][NT];
  logic [WW-1:0] modelS [NP][NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  polyphase_tap_bank #(.SYNC_READ(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEnA), .wrPhase(wrPhase), .wrSample(wrSample),
    .rdPhase(rdPhase), .rdTaps(tapsA), .busy(busyA));

  polyphase_tap_bank #(.SYNC_READ(1'b1)) uutSync (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEnS), .wrPhase(wrPhase), .wrSample(wrSample),
    .rdPhase(rdPhase), .rdTaps(tapsS), .busy(busyS));

  function automatic logic [RW-1:0] rowOf(input bit useSync, input int p);
    logic [RW-1:0] r = '0;
    if (p < NP)
      for (int t = 0; t < NT; t++) r[t*WW +: WW] = useSync ? modelS[p][t] : modelA[p][t];
    return r;
  endfunction

  function automatic logic [WW-1:0] sampleOf(input int n);
    return {16'(n*733 + 17), 16'(n*4099 + 3)};
  endfunction

  task automatic shiftModel(input bit useSync, input int p, input logic [WW-1:0] s);
    if (p < NP) begin
      for (int t = NT-1; t > 0; t--) begin
        if (useSync) modelS[p][t] = modelS[p][t-1];
        else         modelA[p][t] = modelA[p][t-1];
      end
      if (useSync) modelS[p][0] = s; else modelA[p][0] = s;
    end
  endtask

  task automatic check(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Read every index 0..7 from both builds; called at a negedge.
  task automatic scanAll(input string tag);
    for (int p = 0; p < 8; p++) begin
      rdPhase = PW'(p);
      @(posedge clk); @(negedge clk);
      check($sformatf("%s R4 R3 R10 comb phase %0d", tag, p), tapsA, rowOf(1'b0, p));
      check($sformatf("%s R4 R3 R10 reg phase %0d", tag, p), tapsS, rowOf(1'b1, p));
    end
  endtask

  // One load into both builds with reads of the loaded phase on each cycle.
  task automatic loadBoth(input int p, input logic [WW-1:0] s);
    logic [RW-1:0] oldS, newA, newS;
    bit ok;
    ok = (p < NP);
    oldS = rowOf(1'b1, p);
    shiftModel(1'b0, p, s);
    shiftModel(1'b1, p, s);
    newA = rowOf(1'b0, p);
    newS = rowOf(1'b1, p);
    wrEnA = 1'b1; wrEnS = 1'b1; wrPhase = PW'(p); wrSample = s; rdPhase = PW'(p);
    @(posedge clk); @(negedge clk);
    wrEnA = 1'b0; wrEnS = 1'b0;
    check($sformatf("R5 R2 R9 comb after load phase %0d", p), tapsA, newA);
    check($sformatf("R7 reg during load phase %0d", p), tapsS, oldS);
    checkBit($sformatf("R6 R9 busy phase %0d", p), busyS, ok);
    checkBit("R8 comb busy low", busyA, 1'b0);
    @(posedge clk); @(negedge clk);
    check($sformatf("R7 reg at write edge phase %0d", p), tapsS, oldS);
    checkBit("R6 busy drops", busyS, 1'b0);
    @(posedge clk); @(negedge clk);
    check($sformatf("R6 R2 reg after load phase %0d", p), tapsS, newS);
  endtask

  initial begin
    for (int p = 0; p < NP; p++)
      for (int t = 0; t < NT; t++) begin modelA[p][t] = '0; modelS[p][t] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkBit("R1 busy after reset", busyS, 1'b0);
    scanAll("R1 reset");

    // Round-robin and strided phase orders.
    for (int n = 0; n < 30; n++) begin
      loadBoth((n * 3) % NP, sampleOf(n));
      if (n % 10 == 9) scanAll("R2 sweep");
    end
    // One phase loaded repeatedly: old words fall off the end.
    for (int n = 30; n < 39; n++) loadBoth(2, sampleOf(n));
    scanAll("R2 overflow");

    // Out-of-range write indices.
    for (int p = NP; p < 8; p++) loadBoth(p, sampleOf(100 + p));
    scanAll("R9 bad index");

    // Back-to-back loads, combinational build only.
    for (int n = 0; n < 12; n++) begin
      shiftModel(1'b0, n % NP, sampleOf(200 + n));
      wrEnA = 1'b1; wrPhase = PW'(n % NP); wrSample = sampleOf(200 + n);
      @(posedge clk); @(negedge clk);
    end
    wrEnA = 1'b0;
    scanAll("R5 burst");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule